// File: doc/BRIEF.md
# CAN Status Flags and Interrupt Identifier

This block holds the status flags of a CAN controller and derives the interrupt identifier the CPU reads. The protocol engine feeds it single-cycle strobes for a received frame, a transmitted frame, a detected error with its 3-bit code and each run of 11 recessive bits seen during bus-off recovery. It also feeds the current bus-off and warning levels. The block records the receive-OK and transmit-OK flags and the last error code, and it raises a status interrupt when those change under the matching enable.

The identifier combines that status interrupt with 32 per-object pending flags. A pending status change shows as 0x8000 and outranks every message object. Otherwise the lowest-numbered pending object is shown. The CPU clears a status interrupt by reading the status register. It can write code 7 into the error code field and later see whether any bus event has overwritten it.

Top module: `can_stat_irq`

## Requirements
- R1: While reset is held, and in the first cycle after it, the receive-OK flag, the transmit-OK flag, the error code, the identifier and the interrupt line are all zero.
- R2: A clock edge with `ev_err_valid` high loads `ev_err_code` into the error code. The codes are 0 none, 1 stuff, 2 form, 3 ack, 4 bit-1, 5 bit-0, 6 CRC, and 7 no event since the CPU wrote it. Otherwise an `ev_recov_11` strobe loads 5. Otherwise an `ev_rx_ok` or `ev_tx_ok` strobe loads 0.
- R3: `ev_rx_ok` sets the receive-OK flag and `ev_tx_ok` sets the transmit-OK flag. The flags keep their value until a CPU write. A write replaces them from `cpu_wdata`, with bit 4 the receive flag, bit 3 the transmit flag and bits 2:0 the error code. Controller events in the same cycle as a write are applied on top of the written value.
- R4: With no status interrupt pending, `int_id` equals n for the lowest-numbered pending object, where bit n-1 of `obj_pend` belongs to object n. It is 0 when no object is pending. It follows `obj_pend` in the same cycle.
- R5: A pending status interrupt shows as `int_id` = 0x8000, whatever objects are pending.
- R6: With `sie` high, a controller update that changes the receive flag, the transmit flag or the error code makes a status interrupt pending from the next cycle. An update that leaves all three unchanged, or any update made while `sie` is low, does not.
- R7: A change of the `bus_off` or `err_warn` level makes a status interrupt pending only while `eie` is high.
- R8: A CPU write to the status flags never makes a status interrupt pending.
- R9: A `cpu_rd` strobe clears a pending status interrupt from the next cycle. If a new status change arrives in the same cycle as the read, the interrupt stays pending.
- R10: `cpu_irq` is high exactly when `ie` is high and `int_id` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_rx_ok | input | 1 | Strobe: frame received without error |
| ev_tx_ok | input | 1 | Strobe: frame transmitted without error |
| ev_err_valid | input | 1 | Strobe: error detected, code on `ev_err_code` |
| ev_err_code | input | 3 | Error code that goes with `ev_err_valid` |
| ev_recov_11 | input | 1 | Strobe: 11 recessive bits seen during bus-off recovery |
| bus_off | input | 1 | Bus-off level from the protocol engine |
| err_warn | input | 1 | Error warning level from the protocol engine |
| obj_pend | input | 32 | Per-object pending flags, bit n-1 for object n |
| cpu_wr | input | 1 | CPU write strobe for the status register |
| cpu_wdata | input | 5 | Write data: [4] receive-OK, [3] transmit-OK, [2:0] error code |
| cpu_rd | input | 1 | CPU read strobe for the status register |
| ie | input | 1 | Interrupt line enable |
| sie | input | 1 | Status-change interrupt enable |
| eie | input | 1 | Error-level interrupt enable |
| stat_rx_ok | output | 1 | Receive-OK flag |
| stat_tx_ok | output | 1 | Transmit-OK flag |
| stat_err_code | output | 3 | Last error code |
| int_id | output | 16 | Interrupt identifier |
| cpu_irq | output | 1 | Interrupt line to the CPU |

## Verification
If the pending-status register is wrong, `int_id` shows it one cycle after the event or read that should have moved it. There it either holds 0x8000 or fails to take it, whatever objects are pending. A wrong precedence among the error code sources shows up on `stat_err_code` in the cycle after the strobe. A flaw in the priority encoder is combinational, so `int_id` gives the wrong object number at once for the affected pair of pending bits. For that reason the bench sweeps every pair.

// File: rtl/can_si_pkg.sv
// Shared types for the CAN status and interrupt identifier block.
// Assumes a 3-bit error code and a 16-bit identifier.
package can_si_pkg;
    localparam int CODE_W = 3;
    localparam int ID_W   = 16;
    localparam logic [ID_W-1:0] STAT_ID = 16'h8000;

    typedef enum logic [CODE_W-1:0] {
        EC_NONE  = 3'd0,
        EC_STUFF = 3'd1,
        EC_FORM  = 3'd2,
        EC_ACK   = 3'd3,
        EC_BIT1  = 3'd4,
        EC_BIT0  = 3'd5,
        EC_CRC   = 3'd6,
        EC_IDLE  = 3'd7
    } err_code_e;

    typedef struct packed {
        logic      rx_ok;
        logic      tx_ok;
        err_code_e code;
    } stat_t;

    localparam int STAT_W = $bits(stat_t);
endpackage

// File: rtl/can_si_flags.sv
// Status flag register and status-interrupt pending bit.
// Applies a CPU write first and controller events on top of it. Raises
// pending only on a controller-caused value change (under sie) or a change
// of the bus-off or warning level (under eie). Assumes single-cycle strobes.
module can_si_flags
    import can_si_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_rx_ok,
    input  logic              ev_tx_ok,
    input  logic              ev_err_valid,
    input  logic [CODE_W-1:0] ev_err_code,
    input  logic              ev_recov_11,
    input  logic              bus_off,
    input  logic              err_warn,
    input  logic              cpu_wr,
    input  logic [STAT_W-1:0] cpu_wdata,
    input  logic              cpu_rd,
    input  logic              sie,
    input  logic              eie,
    output stat_t             stat,
    output logic              st_pend
);
    stat_t      after_wr;
    stat_t      stat_nxt;
    logic [1:0] lvl_q;
    logic       ctrl_chg;
    logic       lvl_chg;
    logic       st_set;

    // Next flag value: CPU write first, then controller events.
    always_comb begin
        after_wr = cpu_wr ? stat_t'(cpu_wdata) : stat;
        stat_nxt = after_wr;
        if (ev_rx_ok) stat_nxt.rx_ok = 1'b1;
        if (ev_tx_ok) stat_nxt.tx_ok = 1'b1;
        if (ev_err_valid)
            stat_nxt.code = err_code_e'(ev_err_code);
        else if (ev_recov_11)
            stat_nxt.code = EC_BIT0;
        else if (ev_rx_ok || ev_tx_ok)
            stat_nxt.code = EC_NONE;
    end

    // Status-change detection for both enable classes.
    always_comb begin
        ctrl_chg = (stat_nxt != after_wr);
        lvl_chg  = ({bus_off, err_warn} != lvl_q);
        st_set   = (sie && ctrl_chg) || (eie && lvl_chg);
    end

    // Flag register and level history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat  <= '0;
            lvl_q <= '0;
        end else begin
            stat  <= stat_nxt;
            lvl_q <= {bus_off, err_warn};
        end
    end

    // Pending bit: a new change wins over a same-cycle read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_pend <= 1'b0;
        else if (st_set)
            st_pend <= 1'b1;
        else if (cpu_rd)
            st_pend <= 1'b0;
    end
endmodule

// File: rtl/can_si_prio.sv
// Priority encoder over the per-object pending flags.
// The lowest-numbered set flag wins. Bit i gives identifier i+1, none gives 0.
module can_si_prio #(
    parameter int NOBJ = 32,
    parameter int ID_W = 16
) (
    input  logic [NOBJ-1:0] pend,
    output logic [ID_W-1:0] msg_id
);
    // Scan from the top so the lowest index is assigned last.
    always_comb begin
        msg_id = '0;
        for (int i = NOBJ - 1; i >= 0; i--) begin
            if (pend[i]) msg_id = ID_W'(i + 1);
        end
    end
endmodule

// File: rtl/can_stat_irq.sv
// Top of the CAN status and interrupt identifier block.
// Combines the status pending bit with the object priority encoder and
// gates the CPU interrupt line. Assumes NOBJ is below 2**(ID_W-1).
module can_stat_irq
    import can_si_pkg::*;
#(
    parameter int NOBJ = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_rx_ok,
    input  logic              ev_tx_ok,
    input  logic              ev_err_valid,
    input  logic [CODE_W-1:0] ev_err_code,
    input  logic              ev_recov_11,
    input  logic              bus_off,
    input  logic              err_warn,
    input  logic [NOBJ-1:0]   obj_pend,
    input  logic              cpu_wr,
    input  logic [STAT_W-1:0] cpu_wdata,
    input  logic              cpu_rd,
    input  logic              ie,
    input  logic              sie,
    input  logic              eie,
    output logic              stat_rx_ok,
    output logic              stat_tx_ok,
    output logic [CODE_W-1:0] stat_err_code,
    output logic [ID_W-1:0]   int_id,
    output logic              cpu_irq
);
    stat_t           stat;
    logic            st_pend;
    logic [ID_W-1:0] msg_id;

    can_si_flags u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev_rx_ok     (ev_rx_ok),
        .ev_tx_ok     (ev_tx_ok),
        .ev_err_valid (ev_err_valid),
        .ev_err_code  (ev_err_code),
        .ev_recov_11  (ev_recov_11),
        .bus_off      (bus_off),
        .err_warn     (err_warn),
        .cpu_wr       (cpu_wr),
        .cpu_wdata    (cpu_wdata),
        .cpu_rd       (cpu_rd),
        .sie          (sie),
        .eie          (eie),
        .stat         (stat),
        .st_pend      (st_pend)
    );

    can_si_prio #(.NOBJ(NOBJ), .ID_W(ID_W)) u_prio (
        .pend   (obj_pend),
        .msg_id (msg_id)
    );

    // Identifier select and interrupt gating.
    always_comb begin
        stat_rx_ok    = stat.rx_ok;
        stat_tx_ok    = stat.tx_ok;
        stat_err_code = stat.code;
        int_id        = st_pend ? STAT_ID : msg_id;
        cpu_irq       = ie && (int_id != '0);
    end
endmodule

// File: rtl/can_stat_irq_chk.sv
// Port-level checker for can_stat_irq, attached by bind.
// Relies only on the top-level ports and its own history registers.
module can_stat_irq_chk #(
    parameter int NOBJ = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ev_rx_ok,
    input logic            ev_tx_ok,
    input logic            ev_err_valid,
    input logic            ev_recov_11,
    input logic            bus_off,
    input logic            err_warn,
    input logic [NOBJ-1:0] obj_pend,
    input logic            cpu_wr,
    input logic            cpu_rd,
    input logic            ie,
    input logic            stat_rx_ok,
    input logic [2:0]      stat_err_code,
    input logic [15:0]     int_id,
    input logic            cpu_irq
);
    logic [1:0] lvl_h;
    logic       quiet;

    // Level history for detecting bus-off or warning changes.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_h <= '0;
        else        lvl_h <= {bus_off, err_warn};
    end

    always_comb quiet = !ev_rx_ok && !ev_tx_ok && !ev_err_valid && !ev_recov_11
                        && ({bus_off, err_warn} == lvl_h);

    // R4
    id_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_id == 16'h0) || (int_id == 16'h8000) || (int_id <= 16'(NOBJ)));

    // R4
    id_obj_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_id != 16'h0 && int_id != 16'h8000) |-> obj_pend[int_id - 16'd1]);

    // R4
    id_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (obj_pend == '0 && int_id != 16'h8000) |-> int_id == 16'h0);

    // R9
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && quiet) |=> int_id != 16'h8000);

    // R8
    wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && quiet && int_id != 16'h8000) |=> int_id != 16'h8000);

    // R3
    rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rx_ok && !ev_err_valid && !ev_recov_11) |=> (stat_rx_ok && stat_err_code == 3'd0));

    // R10
    irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ie |-> !cpu_irq);
endmodule

bind can_stat_irq can_stat_irq_chk #(.NOBJ(NOBJ)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ev_rx_ok      (ev_rx_ok),
    .ev_tx_ok      (ev_tx_ok),
    .ev_err_valid  (ev_err_valid),
    .ev_recov_11   (ev_recov_11),
    .bus_off       (bus_off),
    .err_warn      (err_warn),
    .obj_pend      (obj_pend),
    .cpu_wr        (cpu_wr),
    .cpu_rd        (cpu_rd),
    .ie            (ie),
    .stat_rx_ok    (stat_rx_ok),
    .stat_err_code (stat_err_code),
    .int_id        (int_id),
    .cpu_irq       (cpu_irq)
);

// File: tb/can_stat_irq_bench.sv
// Self-checking bench: sweeps every pending pair and every error code.
module can_stat_irq_bench;
    localparam int NOBJ = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ev_rx_ok = 0, ev_tx_ok = 0, ev_err_valid = 0, ev_recov_11 = 0;
    logic [2:0]      ev_err_code = '0;
    logic            bus_off = 0, err_warn = 0;
    logic [NOBJ-1:0] obj_pend = '0;
    logic            cpu_wr = 0, cpu_rd = 0;
    logic [4:0]      cpu_wdata = '0;
    logic            ie = 0, sie = 0, eie = 0;
    logic            stat_rx_ok, stat_tx_ok, cpu_irq;
    logic [2:0]      stat_err_code;
    logic [15:0]     int_id;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    can_stat_irq #(.NOBJ(NOBJ)) u_can_stat_irq (
        .clk(clk), .rst_n(rst_n), .ev_rx_ok(ev_rx_ok), .ev_tx_ok(ev_tx_ok),
        .ev_err_valid(ev_err_valid), .ev_err_code(ev_err_code),
        .ev_recov_11(ev_recov_11), .bus_off(bus_off), .err_warn(err_warn),
        .obj_pend(obj_pend), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .ie(ie), .sie(sie), .eie(eie),
        .stat_rx_ok(stat_rx_ok), .stat_tx_ok(stat_tx_ok),
        .stat_err_code(stat_err_code), .int_id(int_id), .cpu_irq(cpu_irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    // One clock: inputs held from this negedge to the next.
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic clear_ev();
        ev_rx_ok = 0; ev_tx_ok = 0; ev_err_valid = 0; ev_recov_11 = 0;
        cpu_wr = 0; cpu_rd = 0;
    endtask

    task automatic status_read();
        cpu_rd = 1; tick(); clear_ev();
    endtask

    task automatic status_write(input logic [4:0] v);
        cpu_wr = 1; cpu_wdata = v; tick(); clear_ev();
    endtask

    initial begin
        repeat (3) tick();
        chk("R1 id in reset", int_id, 0);
        chk("R1 irq in reset", cpu_irq, 0);
        rst_n = 1; tick();
        chk("R1 flags", {stat_rx_ok, stat_tx_ok, stat_err_code}, 0);
        chk("R1 id", int_id, 0);

        // R4 / R10: every pair of pending objects
        for (int i = 0; i < NOBJ; i++) begin
            for (int j = i; j < NOBJ; j++) begin
                obj_pend = (32'd1 << i) | (32'd1 << j);
                ie = ((i + j) % 2) == 1;
                #1;
                chk("R4 lowest object", int_id, i + 1);
                chk("R10 irq gate", cpu_irq, ie);
            end
        end
        obj_pend = '0; ie = 1; #1;
        chk("R4 none pending", int_id, 0);
        chk("R10 irq idle", cpu_irq, 0);
        tick();

        // R2 / R6 / R8 / R9: each error code after seeding 7
        sie = 1;
        for (int c = 0; c < 8; c++) begin
            status_write(5'b00111);
            chk("R8 write no int", int_id, 0);
            chk("R3 write code", stat_err_code, 7);
            ev_err_valid = 1; ev_err_code = 3'(c); tick(); clear_ev();
            chk("R2 code load", stat_err_code, c);
            chk("R6 change int", int_id, (c != 7) ? 32'h8000 : 32'h0);
            chk("R10 irq status", cpu_irq, c != 7);
            status_read();
            chk("R9 read clears", int_id, 0);
        end

        // R3 / R6: receive and transmit flags
        ev_rx_ok = 1; tick(); clear_ev();
        chk("R3 rx set", {stat_rx_ok, stat_err_code}, 4'b1000);
        chk("R6 rx change", int_id, 32'h8000);
        status_read();
        ev_tx_ok = 1; tick(); clear_ev();
        chk("R3 tx set", {stat_rx_ok, stat_tx_ok}, 2'b11);
        status_read();
        ev_rx_ok = 1; tick(); clear_ev();
        chk("R6 no change no int", int_id, 0);
        chk("R3 flags held", {stat_rx_ok, stat_tx_ok}, 2'b11);

        // R3: write and event in the same cycle
        cpu_wr = 1; cpu_wdata = 5'b00011; ev_tx_ok = 1; tick(); clear_ev();
        chk("R3 event over write", {stat_rx_ok, stat_tx_ok, stat_err_code}, 5'b01000);
        status_read();

        // R6: sie low blocks
        sie = 0;
        ev_err_valid = 1; ev_err_code = 3'd3; tick(); clear_ev();
        chk("R6 sie off code", stat_err_code, 3);
        chk("R6 sie off no int", int_id, 0);
        ev_recov_11 = 1; tick(); clear_ev();
        chk("R2 recovery code", stat_err_code, 5);
        ev_recov_11 = 1; ev_rx_ok = 1; ev_err_valid = 1; ev_err_code = 3'd6; tick(); clear_ev();
        chk("R2 error wins", stat_err_code, 6);

        // R7: level changes
        eie = 1; bus_off = 1; tick();
        chk("R7 bus-off int", int_id, 32'h8000);
        status_read();
        eie = 0; err_warn = 1; tick();
        chk("R7 eie off", int_id, 0);

        // R5 / R9: status outranks objects, read reveals object
        obj_pend = 32'h10; eie = 1; err_warn = 0; tick();
        chk("R5 status over object", int_id, 32'h8000);
        bus_off = 0; cpu_rd = 1; tick(); clear_ev();
        chk("R9 change beats read", int_id, 32'h8000);
        status_read();
        chk("R9 read shows object", int_id, 5);
        obj_pend = '0; #1;
        chk("R4 object cleared", int_id, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog got=hung exp=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule